// File: doc/BRIEF.md
# Shadow Register Commit Controller

This block keeps two copies of a bank of display configuration words. Software writes go only to the shadow copy. The compositing and timing logic reads only the active copy. The shadow copy moves into the active copy as one step, at a frame-boundary strobe from the timing generator. Two conditions must both hold for that move: an update has been requested, and the protect input is low.

Software sets protect, rewrites as many words as it needs, clears protect, and then pulses the update request. Because of this order, a half-finished edit never reaches the active copy in the middle of a frame. The pending flag stays high from the request until the copy has taken place. There are two read ports. One returns shadow words and the other returns active words, so software can see both what it wrote and what is in use.

Top module: `shadow_commit_ctrl`

## Requirements
- R1: During reset, register i of both copies loads RESET_BASE + i, and update_pending clears to 0.
- R2: A write with wr_en high and wr_addr below NUM_REGS changes that shadow word on the next clock edge. The active copy does not change.
- R3: A write to an address of NUM_REGS or above changes no word. A read of such an address returns 0 on both read ports.
- R4: A cycle with update_req high sets update_pending on the next edge.
- R5: A commit copies every shadow word into the active copy. It happens on an edge where frame_start is high, update_pending is already 1 and protect is 0. The new values are visible after that edge.
- R6: While protect is 1, frame_start copies nothing and update_pending stays 1.
- R7: While update_pending is 0, frame_start leaves the active copy unchanged.
- R8: A commit clears update_pending, unless update_req is high in the same cycle, in which case update_pending stays 1.
- R9: A shadow write in the same cycle as a commit is not part of that commit. The active word takes the shadow value from before the write.
- R10: If update_req and frame_start are both high while update_pending is 0, no copy happens at that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Shadow write strobe |
| wr_addr | input | ADDR_W | Shadow write word index |
| wr_data | input | DATA_W | Shadow write data |
| rd_addr | input | ADDR_W | Word index for both read ports |
| rd_shadow_data | output | DATA_W | Shadow word at rd_addr, or 0 if the address is out of range |
| rd_active_data | output | DATA_W | Active word at rd_addr, or 0 if the address is out of range |
| frame_start | input | 1 | Frame-boundary strobe from the timing generator |
| protect | input | 1 | Blocks any commit while high |
| update_req | input | 1 | Single-cycle request to commit |
| update_pending | output | 1 | A requested commit has not yet happened |
| active_flat | output | NUM_REGS*DATA_W | All active words; word i is at bits [i*DATA_W +: DATA_W] |

## Verification
Some rules are checked by the assertions on every cycle. The active copy changes only on a commit edge, and when it does it equals the shadow copy from the previous cycle. The pending flag rises after a request, holds while it is blocked, and falls after a commit that has no new request beside it. Other behaviour can only be shown by the bench scenarios, because it depends on ordered stimulus: the reset values, out-of-range writes that are ignored, a write in the same cycle as a commit, and a request that arrives together with the strobe it must not use.

// File: rtl/scc_pkg.sv
// Package: shared helpers for the shadow commit controller.
// Assumes: words are at most 64 bits wide.
package scc_pkg;
    // Reset value of word idx: the base plus the word index.
    function automatic logic [63:0] reg_default(logic [63:0] base, int unsigned idx);
        return base + 64'(idx);
    endfunction
endpackage

// File: rtl/scc_shadow_bank.sv
// Module: shadow copy of the configuration words, written by the bus.
// Assumes: NUM_REGS <= 2**ADDR_W; writes to other addresses are dropped.
module scc_shadow_bank #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter logic [DATA_W-1:0] RESET_BASE = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic [NUM_REGS*DATA_W-1:0] shadow_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        localparam logic [DATA_W-1:0] DEF =
            DATA_W'(scc_pkg::reg_default(64'(RESET_BASE), i));
        // Hold word i: load the default during reset, take bus data on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow_flat[i*DATA_W +: DATA_W] <= DEF;
            else if (wr_en && (wr_addr == ADDR_W'(i)))
                shadow_flat[i*DATA_W +: DATA_W] <= wr_data;
        end
    end
endmodule

// File: rtl/scc_commit_ctrl.sv
// Module: request tracking and the commit decision.
// Assumes: frame_start and update_req are single-cycle pulses; protect is a level.
module scc_commit_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic update_req,
    input  logic protect,
    input  logic frame_start,
    output logic update_pending,
    output logic commit
);
    // Commit only on a strobe that meets an earlier request with protect low.
    always_comb commit = frame_start && update_pending && !protect;

    // Track the request; a request in the commit cycle stays pending.
    always_ff @(posedge clk) begin
        if (!rst_n)
            update_pending <= 1'b0;
        else
            update_pending <= update_req || (update_pending && !commit);
    end
endmodule

// File: rtl/scc_active_bank.sv
// Module: active copy, loaded from the whole shadow copy in one edge.
// Assumes: commit is a single-cycle pulse from scc_commit_ctrl.
module scc_active_bank #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] RESET_BASE = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic [NUM_REGS*DATA_W-1:0] shadow_flat,
    output logic [NUM_REGS*DATA_W-1:0] active_flat
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        localparam logic [DATA_W-1:0] DEF =
            DATA_W'(scc_pkg::reg_default(64'(RESET_BASE), i));
        // Hold active word i: load the default during reset, copy the shadow word on commit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                active_flat[i*DATA_W +: DATA_W] <= DEF;
            else if (commit)
                active_flat[i*DATA_W +: DATA_W] <= shadow_flat[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/scc_read_mux.sv
// Module: combinational word select from a flat bank.
// Assumes: an address outside the bank reads as zero.
module scc_read_mux #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [NUM_REGS*DATA_W-1:0] bank_flat,
    output logic [DATA_W-1:0]          rd_data
);
    // Pick the addressed word; no match gives zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == ADDR_W'(i))
                rd_data = bank_flat[i*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/shadow_commit_ctrl.sv
// Module: top of the shadow register commit controller.
// Tracks bus writes in a shadow copy and moves them to the active copy at a
// frame boundary when an update is pending and protect is low.
// Assumes: NUM_REGS <= 2**ADDR_W; synchronous active-low reset.
module shadow_commit_ctrl #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter logic [DATA_W-1:0] RESET_BASE = DATA_W'(32'h0000_1000)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_shadow_data,
    output logic [DATA_W-1:0]          rd_active_data,
    input  logic                       frame_start,
    input  logic                       protect,
    input  logic                       update_req,
    output logic                       update_pending,
    output logic [NUM_REGS*DATA_W-1:0] active_flat
);
    localparam int BANK_W = NUM_REGS * DATA_W;

    logic [BANK_W-1:0] shadow_flat;
    logic              commit;

    scc_shadow_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                      .RESET_BASE(RESET_BASE)) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .shadow_flat(shadow_flat));

    scc_commit_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .update_req(update_req), .protect(protect),
        .frame_start(frame_start), .update_pending(update_pending), .commit(commit));

    scc_active_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
                      .RESET_BASE(RESET_BASE)) u_active (
        .clk(clk), .rst_n(rst_n), .commit(commit), .shadow_flat(shadow_flat),
        .active_flat(active_flat));

    scc_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_shadow (
        .rd_addr(rd_addr), .bank_flat(shadow_flat), .rd_data(rd_shadow_data));

    scc_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_active (
        .rd_addr(rd_addr), .bank_flat(active_flat), .rd_data(rd_active_data));
endmodule

// File: rtl/scc_checker.sv
// Module: temporal checks for shadow_commit_ctrl, attached by bind below.
// Assumes: it sees the top's internal shadow bank through the bind connection.
module scc_checker #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       frame_start,
    input logic                       protect,
    input logic                       update_req,
    input logic                       update_pending,
    input logic [NUM_REGS*DATA_W-1:0] active_flat,
    input logic [NUM_REGS*DATA_W-1:0] shadow_flat
);
    p_copy_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && update_pending && !protect) |=> (active_flat == $past(shadow_flat)));

    // Covers R6 and R7: no commit condition, so the active copy holds.
    p_hold_when_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start && update_pending && !protect) |=> $stable(active_flat));

    p_pending_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        update_req |=> update_pending);

    p_pending_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && update_pending && !protect && !update_req) |=> !update_pending);

    p_pending_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (update_pending && (protect || !frame_start)) |=> update_pending);
endmodule

bind shadow_commit_ctrl scc_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .protect(protect),
    .update_req(update_req), .update_pending(update_pending),
    .active_flat(active_flat), .shadow_flat(shadow_flat));

// File: tb/shadow_commit_ctrl_bench.sv
// Bench: directed scenarios plus random traffic, with a behavioural
// reference model compared on every falling edge.
module shadow_commit_ctrl_bench;
    localparam int N = 8;
    localparam int W = 32;
    localparam int AW = 4;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [W-1:0] rd_shadow_data, rd_active_data;
    logic frame_start = 1'b0, protect = 1'b0, update_req = 1'b0;
    logic update_pending;
    logic [N*W-1:0] active_flat;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit started = 1'b0;
    bit finished = 1'b0;

    // Reference model state
    logic [31:0] m_sh [N];
    logic [31:0] m_ac [N];
    bit m_pend;

    shadow_commit_ctrl #(.NUM_REGS(N), .DATA_W(W), .ADDR_W(AW), .RESET_BASE(BASE))
        u_shadow_commit_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_shadow_data(rd_shadow_data), .rd_active_data(rd_active_data),
        .frame_start(frame_start), .protect(protect), .update_req(update_req),
        .update_pending(update_pending), .active_flat(active_flat));

    always #2 clk = ~clk;

    function automatic logic [31:0] act(int i);
        return active_flat[i*W +: W];
    endfunction

    task automatic chk(string tag, logic [31:0] actual, logic [31:0] expected);
        total++;
        if (actual !== expected) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, actual, expected, $time);
        end
    endtask

    // Reference model, updated on the same edge as the design
    always @(posedge clk) begin
        bit c;
        c = frame_start && m_pend && !protect;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_sh[i] <= BASE + 32'(i);
                m_ac[i] <= BASE + 32'(i);
            end
            m_pend <= 1'b0;
        end else begin
            if (wr_en && int'(wr_addr) < N) m_sh[int'(wr_addr)] <= wr_data;
            if (c) for (int i = 0; i < N; i++) m_ac[i] <= m_sh[i];
            m_pend <= update_req || (m_pend && !c);
        end
    end

    // Compare against the model away from the active edge; scan the read address
    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R4 pending", 32'(update_pending), 32'(m_pend));
            for (int i = 0; i < N; i++) chk("R5 active word", act(i), m_ac[i]);
            chk("R2 shadow read", rd_shadow_data,
                (int'(rd_addr) < N) ? m_sh[int'(rd_addr)] : 32'h0);
            chk("R3 active read", rd_active_data,
                (int'(rd_addr) < N) ? m_ac[int'(rd_addr)] : 32'h0);
            rd_addr <= rd_addr + 1'b1;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(int a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic strobe();
        frame_start = 1'b1;
        step();
        frame_start = 1'b0;
    endtask

    task automatic request();
        update_req = 1'b1;
        step();
        update_req = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        started = 1'b1;

        // R1: reset state of both copies and the flag
        chk("R1 active0", act(0), BASE);
        chk("R1 active7", act(7), BASE + 32'd7);
        chk("R1 pending", 32'(update_pending), 32'h0);

        // R2: shadow writes under protect leave the active copy alone
        protect = 1'b1;
        wr(0, 32'hA000_0000);
        wr(1, 32'hA111_1111);
        wr(9, 32'hDEAD_BEEF);
        chk("R2 active0 unchanged", act(0), BASE);

        // R4 and R6: a request is held while protected
        request();
        chk("R4 pending set", 32'(update_pending), 32'h1);
        strobe();
        chk("R6 pending held", 32'(update_pending), 32'h1);
        chk("R6 no copy", act(0), BASE);

        // R5, R8 and R9: commit, with a write in the same cycle
        protect = 1'b0;
        step();
        wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'hB111_1111; frame_start = 1'b1;
        step();
        wr_en = 1'b0; frame_start = 1'b0;
        chk("R5 active0 copied", act(0), 32'hA000_0000);
        chk("R9 active1 pre-write", act(1), 32'hA111_1111);
        chk("R8 pending cleared", 32'(update_pending), 32'h0);
        for (int i = 2; i < N; i++) chk("R3 untouched word", act(i), BASE + 32'(i));

        // R7: a strobe without a request copies nothing
        wr(0, 32'hC000_0000);
        strobe();
        chk("R7 no copy", act(0), 32'hA000_0000);

        // R10: request together with the strobe waits for the next strobe
        update_req = 1'b1; frame_start = 1'b1;
        step();
        update_req = 1'b0; frame_start = 1'b0;
        chk("R10 no copy", act(0), 32'hA000_0000);
        chk("R10 pending", 32'(update_pending), 32'h1);
        strobe();
        chk("R5 active0 second", act(0), 32'hC000_0000);
        chk("R5 active1 second", act(1), 32'hB111_1111);

        // R8: a request in the commit cycle keeps the flag
        request();
        update_req = 1'b1; frame_start = 1'b1;
        step();
        update_req = 1'b0; frame_start = 1'b0;
        chk("R8 pending kept", 32'(update_pending), 32'h1);

        // Random traffic compared against the model
        for (int k = 0; k < 3000; k++) begin
            wr_en = ($urandom_range(1, 0) == 1);
            wr_addr = AW'($urandom_range(15, 0));
            wr_data = $urandom();
            frame_start = ($urandom_range(6, 0) == 0);
            update_req = ($urandom_range(9, 0) == 0);
            if ($urandom_range(9, 0) == 0) protect = ~protect;
            step();
        end
        wr_en = 1'b0; frame_start = 1'b0; update_req = 1'b0;
        step();
        finish_run();
    end
endmodule